// File: doc/BRIEF.md
# ECC engine control-status register file

This block is the software-facing register file that sits in front of a NAND error-correction encoder and decoder. It decodes a small 32-bit register bus. For each direction it keeps an enable (control) word, a configuration word, an idle flag, an interrupt enable and an interrupt status. For the decoder it also keeps a bitmask of finished sectors, and for the encoder a source address word. It drives one interrupt line.

The encode and decode cores are stand-in stubs. Each stub starts when its control word is written with 1, stops when it is written with 0, and reports one completion per sector. A sector takes `STEP_CYC` cycles. The number of sectors comes from the configuration word.

Software starts an engine by writing its configuration and then writing 1 to its control word. It then either polls the idle flag or waits for the interrupt. The interrupt can fire once per ECC step or once per page. Status and the done mask clear when they are read, so the interrupt handler needs only reads. The decoder message size that software places in the configuration is the data byte count times eight, plus the strength times the parity bits per correctable bit.

Top module: `ecc_csr_block`

## Requirements
- R1: Register map (byte addresses, 32-bit data). Encoder registers: control 0x000 (bit 0), config 0x004 (32 bits), source address 0x008 (32 bits), idle 0x00C, interrupt enable 0x020 (bits 1:0), interrupt status 0x024 (bit 0). Decoder registers: control 0x100, config 0x104, idle 0x10C, done mask 0x110, interrupt enable 0x120, interrupt status 0x124. Config error register: 0x140. Writable registers read back what was written, and any unmapped address reads 0.
- R2: `req_ready` is always 1. Every accepted read returns its data with `rsp_valid` high for exactly the one cycle after acceptance, and `rsp_valid` is never high at any other time.
- R3: Idle bit 0 reads 1 when that engine is stopped and 0 while it runs. Writing 1 to a control word starts its engine. Writing 0 stops it at once, and no further sector completes.
- R4: Config bits [8 +: log2(NUM_SECT)] hold the sector count minus one. A run of N sectors keeps the engine busy for exactly N*STEP_CYC cycles after the start write.
- R5: In the decoder done mask, bit i sets when sector i finishes. After an N-sector run with no reads in between, the mask equals 2^N-1, and bit N-1 is the last to set.
- R6: Reading an interrupt status register or the done mask returns the current value and clears it. A bit that sets in the same cycle as such a read survives the clear.
- R7: Interrupt enable bit 1 set to 0 makes status bit 0 set on every sector completion. Set to 1, it makes status bit 0 set only on the last sector of the run.
- R8: `irq` is high exactly when some direction has status bit 0 set and enable bit 0 set. It follows those bits one cycle later.
- R9: A config write while its engine is busy is ignored. It sets a sticky error bit at 0x140: bit 0 for the encoder, bit 1 for the decoder. Writing 1 to an error bit clears it.
- R10: Encoder sector completions set only encoder status and never touch the decoder done mask.
- R11: After reset every register reads 0, both idle bits read 1, and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Bus request valid |
| req_ready | output | 1 | Bus request ready (always 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read is accepted |
| rsp_rdata | output | 32 | Read data |
| irq | output | 1 | Combined interrupt line |

## Verification
The bench sweeps every sector count in both directions and in both interrupt modes. At the end of each run it compares the done mask against 2^N-1. A design with an off-by-one in the sector field would leave the top bit clear or set one bit too many.

Page mode is checked in the middle of a run. An engine that ignored the page selection would raise `irq` after the first step.

Reads are also placed on the exact cycle in which a new sector sets status and mask. A clear that had priority over the set would lose a completion, and the re-read after it would come back empty.

Busy-length probes at cycle N*STEP_CYC and N*STEP_CYC+1 catch a stub that runs one step short or long. A mid-run stop followed by a long wait shows whether completions keep arriving after the engine was halted.

// File: rtl/ecc_csr_pkg.sv
package ecc_csr_pkg;
  localparam int CSR_AW = 12;
  localparam int CSR_DW = 32;

  // Per-direction bases; the per-engine offsets below are added to these
  localparam logic [CSR_AW-1:0] ENC_BASE = 12'h000;
  localparam logic [CSR_AW-1:0] DEC_BASE = 12'h100;

  localparam logic [CSR_AW-1:0] OFS_CTRL = 12'h000;
  localparam logic [CSR_AW-1:0] OFS_CFG  = 12'h004;
  localparam logic [CSR_AW-1:0] OFS_IDLE = 12'h00C;
  localparam logic [CSR_AW-1:0] OFS_IEN  = 12'h020;
  localparam logic [CSR_AW-1:0] OFS_IST  = 12'h024;

  // Single-instance registers
  localparam logic [CSR_AW-1:0] ADR_SRC  = 12'h008;
  localparam logic [CSR_AW-1:0] ADR_MASK = 12'h110;
  localparam logic [CSR_AW-1:0] ADR_ERR  = 12'h140;

  // Sector-count field position inside a config word
  localparam int SECT_LSB = 8;

  typedef enum logic [0:0] {DIR_ENC = 1'b0, DIR_DEC = 1'b1} ecc_dir_e;
endpackage

// File: rtl/ecc_step_stub.sv
// Stand-in for an ECC core: runs (last_idx+1) sectors of STEP_CYC cycles each
module ecc_step_stub #(
  parameter int NUM_SECT = 8,
  parameter int STEP_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic abort,
  input  logic [((NUM_SECT > 1) ? $clog2(NUM_SECT) : 1)-1:0] last_idx,
  output logic busy,
  output logic done_p,
  output logic [((NUM_SECT > 1) ? $clog2(NUM_SECT) : 1)-1:0] done_idx,
  output logic done_last
);
  localparam int SECT_W = (NUM_SECT > 1) ? $clog2(NUM_SECT) : 1;
  localparam int CNT_W  = (STEP_CYC > 1) ? $clog2(STEP_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(STEP_CYC - 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [SECT_W-1:0] sec_q;
  logic [SECT_W-1:0] last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      cnt_q     <= '0;
      sec_q     <= '0;
      last_q    <= '0;
      done_p    <= 1'b0;
      done_idx  <= '0;
      done_last <= 1'b0;
    end else begin
      done_p    <= 1'b0;
      done_last <= 1'b0;
      if (abort) begin
        busy <= 1'b0;
      end else if (start && !busy) begin
        busy   <= 1'b1;
        cnt_q  <= '0;
        sec_q  <= '0;
        last_q <= last_idx;
      end else if (busy) begin
        if (cnt_q == CNT_END) begin
          cnt_q     <= '0;
          done_p    <= 1'b1;
          done_idx  <= sec_q;
          done_last <= (sec_q == last_q);
          if (sec_q == last_q) busy <= 1'b0;
          else                 sec_q <= sec_q + 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ecc_irq_chan.sv
// One direction's interrupt enable / read-to-clear status pair
module ecc_irq_chan #(
  parameter bit PAGE_OK = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ien_wr,
  input  logic [1:0] ien_wdata,
  input  logic       st_rd,
  input  logic       done_p,
  input  logic       done_last,
  output logic [1:0] ien_q,
  output logic       st_q,
  output logic       irq_term
);
  logic page_sel;
  logic page_wr;
  logic st_set;

  generate
    if (PAGE_OK) begin : g_page
      assign page_sel = ien_q[1];
      assign page_wr  = ien_wdata[1];
    end else begin : g_step_only
      assign page_sel = 1'b0;
      assign page_wr  = 1'b0;
    end
  endgenerate

  // Page mode: only the final sector of a run raises status
  assign st_set = done_p && (!page_sel || done_last);

  always_ff @(posedge clk) begin
    if (rst) begin
      ien_q <= 2'b00;
      st_q  <= 1'b0;
    end else begin
      if (ien_wr) ien_q <= {page_wr, ien_wdata[0]};
      // Set beats the read-clear so a coincident completion is not lost
      st_q <= st_set | (st_q & ~st_rd);
    end
  end

  assign irq_term = st_q & ien_q[0];
endmodule

// File: rtl/ecc_csr_block.sv
module ecc_csr_block
  import ecc_csr_pkg::*;
#(
  parameter int NUM_SECT    = 8,
  parameter int STEP_CYC    = 4,
  parameter bit PAGE_IRQ_OK = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [CSR_AW-1:0] req_addr,
  input  logic [CSR_DW-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [CSR_DW-1:0] rsp_rdata,
  output logic              irq
);
  localparam int SECT_W = (NUM_SECT > 1) ? $clog2(NUM_SECT) : 1;

  logic wr_en, rd_en;
  logic [1:0] ctrl_hit, cfg_hit, idle_hit, ien_hit, ist_hit;
  logic src_hit, mask_hit, err_hit;

  logic [1:0]        ctrl_q;
  logic [CSR_DW-1:0] cfg_q [2];
  logic [CSR_DW-1:0] src_q;
  logic [1:0]        ien_q [2];
  logic [1:0]        st_q;
  logic [1:0]        err_q;
  logic [1:0]        err_set;
  logic [NUM_SECT-1:0] dmask_q;
  logic [NUM_SECT-1:0] dmask_set;

  logic [1:0]        busy, done_p, done_last, irq_term;
  logic [SECT_W-1:0] done_idx [2];
  logic [CSR_DW-1:0] rd_mux;

  assign req_ready = 1'b1;
  assign wr_en = req_valid & req_write;
  assign rd_en = req_valid & ~req_write;

  assign src_hit  = (req_addr == ADR_SRC);
  assign mask_hit = (req_addr == ADR_MASK);
  assign err_hit  = (req_addr == ADR_ERR);

  generate
    for (genvar d = 0; d < 2; d++) begin : g_dir
      localparam logic [CSR_AW-1:0] BASE = (d == int'(DIR_DEC)) ? DEC_BASE : ENC_BASE;

      assign ctrl_hit[d] = (req_addr == (BASE | OFS_CTRL));
      assign cfg_hit[d]  = (req_addr == (BASE | OFS_CFG));
      assign idle_hit[d] = (req_addr == (BASE | OFS_IDLE));
      assign ien_hit[d]  = (req_addr == (BASE | OFS_IEN));
      assign ist_hit[d]  = (req_addr == (BASE | OFS_IST));

      // A config write to a running engine is dropped and flagged
      assign err_set[d] = wr_en & cfg_hit[d] & busy[d];

      ecc_step_stub #(
        .NUM_SECT (NUM_SECT),
        .STEP_CYC (STEP_CYC)
      ) u_stub (
        .clk       (clk),
        .rst       (rst),
        .start     (wr_en & ctrl_hit[d] & req_wdata[0]),
        .abort     (wr_en & ctrl_hit[d] & ~req_wdata[0]),
        .last_idx  (cfg_q[d][SECT_LSB +: SECT_W]),
        .busy      (busy[d]),
        .done_p    (done_p[d]),
        .done_idx  (done_idx[d]),
        .done_last (done_last[d])
      );

      ecc_irq_chan #(
        .PAGE_OK (PAGE_IRQ_OK)
      ) u_chan (
        .clk       (clk),
        .rst       (rst),
        .ien_wr    (wr_en & ien_hit[d]),
        .ien_wdata (req_wdata[1:0]),
        .st_rd     (rd_en & ist_hit[d]),
        .done_p    (done_p[d]),
        .done_last (done_last[d]),
        .ien_q     (ien_q[d]),
        .st_q      (st_q[d]),
        .irq_term  (irq_term[d])
      );
    end
  endgenerate

  assign dmask_set = done_p[DIR_DEC] ? (NUM_SECT'(1) << done_idx[DIR_DEC]) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= 2'b00;
      cfg_q   <= '{default: '0};
      src_q   <= '0;
      err_q   <= 2'b00;
      dmask_q <= '0;
    end else begin
      for (int d = 0; d < 2; d++) begin
        if (wr_en && ctrl_hit[d]) ctrl_q[d] <= req_wdata[0];
        if (wr_en && cfg_hit[d] && !busy[d]) cfg_q[d] <= req_wdata;
      end
      if (wr_en && src_hit) src_q <= req_wdata;
      err_q   <= ((wr_en && err_hit) ? (err_q & ~req_wdata[1:0]) : err_q) | err_set;
      dmask_q <= ((rd_en && mask_hit) ? '0 : dmask_q) | dmask_set;
    end
  end

  always_comb begin
    rd_mux = '0;
    for (int d = 0; d < 2; d++) begin
      if (ctrl_hit[d]) rd_mux = {31'b0, ctrl_q[d]};
      if (cfg_hit[d])  rd_mux = cfg_q[d];
      if (idle_hit[d]) rd_mux = {31'b0, ~busy[d]};
      if (ien_hit[d])  rd_mux = {30'b0, ien_q[d]};
      if (ist_hit[d])  rd_mux = {31'b0, st_q[d]};
    end
    if (src_hit)  rd_mux = src_q;
    if (mask_hit) rd_mux = CSR_DW'(dmask_q);
    if (err_hit)  rd_mux = {30'b0, err_q};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      rsp_valid <= rd_en;
      if (rd_en) rsp_rdata <= rd_mux;
      irq <= |irq_term;
    end
  end
endmodule

// File: rtl/ecc_csr_block_chk.sv
module ecc_csr_block_chk (
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic        req_write,
  input logic        rsp_valid,
  input logic        irq,
  input logic [1:0]  ien_en,
  input logic        dec_page,
  input logic        dec_st,
  input logic [1:0]  busy,
  input logic [31:0] enc_cfg,
  input logic [31:0] dec_cfg
);
  // R2
  rd_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write) |=> rsp_valid);

  // R2
  rsp_source_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(req_valid && !req_write));

  // R9
  enc_cfg_lock_chk: assert property (@(posedge clk) disable iff (rst)
    $past(busy[0]) |-> $stable(enc_cfg));

  // R9
  dec_cfg_lock_chk: assert property (@(posedge clk) disable iff (rst)
    $past(busy[1]) |-> $stable(dec_cfg));

  // R8
  irq_masked_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(ien_en) == 2'b00) |-> !irq);

  // R7
  page_irq_end_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(dec_st) && $past(dec_page)) |-> !$past(busy[1]));
endmodule

bind ecc_csr_block ecc_csr_block_chk chk_i (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_write (req_write),
  .rsp_valid (rsp_valid),
  .irq       (irq),
  .ien_en    ({ien_q[1][0], ien_q[0][0]}),
  .dec_page  (ien_q[1][1]),
  .dec_st    (st_q[1]),
  .busy      (busy),
  .enc_cfg   (cfg_q[0]),
  .dec_cfg   (cfg_q[1])
);

// File: tb/ecc_csr_block_tb_top.sv
`timescale 1ns/1ps
module ecc_csr_block_tb_top;
  localparam int NS   = 8;
  localparam int STEP = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [11:0] req_addr  = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  ecc_csr_block #(.NUM_SECT(NS), .STEP_CYC(STEP), .PAGE_IRQ_OK(1'b1)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // All bus tasks start and end just after a falling edge
  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    d = rsp_rdata;
    if (rsp_valid !== 1'b1) begin
      checks++; fails++;
      $display("FAIL R2: rsp_valid actual %b expected 1", rsp_valid);
    end
  endtask

  task automatic run_case(input int dir, input int n, input int page);
    logic [11:0] b;
    logic [31:0] cfgv, v;
    b = (dir != 0) ? 12'h100 : 12'h000;
    cfgv = (32'(n - 1) << 8) | 32'h3;
    if (dir != 0) cfgv = cfgv | 32'h8000_3000 | (32'(512 * 8 + 8 * 14) << 16);
    bus_write(b | 12'h020, {30'b0, page[0], 1'b1});
    bus_write(b | 12'h004, cfgv);
    bus_read(b | 12'h004, v);  chk("R1 cfg readback", v, cfgv);
    bus_write(b, 32'h1);
    bus_read(b | 12'h00C, v);  chk("R3 idle low while running", v, 0);
    if (n >= 2) begin
      repeat (STEP + 1) @(negedge clk);
      chk("R7 irq after first step", {31'b0, irq}, (page != 0) ? 0 : 1);
    end
    repeat (n * STEP + 2) @(negedge clk);
    chk("R8 irq at run end", {31'b0, irq}, 1);
    bus_read(b | 12'h00C, v);  chk("R3 idle after run", v, 1);
    bus_read(12'h110, v);
    if (dir != 0) begin
      chk("R5 done mask", v, (32'h1 << n) - 1);
      bus_read(12'h110, v);    chk("R6 done mask cleared", v, 0);
    end else begin
      chk("R10 enc leaves done mask", v, 0);
    end
    bus_read(b | 12'h024, v);  chk("R7 status set", v, 1);
    @(negedge clk);
    chk("R8 irq drops after status read", {31'b0, irq}, 0);
    bus_read(b | 12'h024, v);  chk("R6 status cleared", v, 0);
    bus_write(b, 32'h0);
  endtask

  initial begin
    logic [31:0] v;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R11 reset state
    chk("R11 irq", {31'b0, irq}, 0);
    chk("R2 ready", {31'b0, req_ready}, 1);
    bus_read(12'h000, v); chk("R11 enc ctrl", v, 0);
    bus_read(12'h004, v); chk("R11 enc cfg", v, 0);
    bus_read(12'h00C, v); chk("R11 enc idle", v, 1);
    bus_read(12'h104, v); chk("R11 dec cfg", v, 0);
    bus_read(12'h10C, v); chk("R11 dec idle", v, 1);
    bus_read(12'h110, v); chk("R11 done mask", v, 0);
    bus_read(12'h124, v); chk("R11 dec status", v, 0);
    bus_read(12'h140, v); chk("R11 error", v, 0);
    @(negedge clk);
    chk("R2 rsp_valid single cycle", {31'b0, rsp_valid}, 0);

    // R1 plain registers and unmapped space
    bus_write(12'h008, 32'hCAFE_0123);
    bus_read(12'h008, v); chk("R1 source addr", v, 32'hCAFE_0123);
    bus_write(12'h120, 32'hFFFF_FFFF);
    bus_read(12'h120, v); chk("R1 dec ien width", v, 3);
    bus_read(12'h108, v); chk("R1 unmapped 0x108", v, 0);
    bus_read(12'h3FC, v); chk("R1 unmapped 0x3FC", v, 0);

    // Full sweep: direction x sector count x interrupt mode
    for (int dir = 0; dir < 2; dir++)
      for (int n = 1; n <= NS; n++)
        for (int page = 0; page < 2; page++)
          run_case(dir, n, page);

    // R4 exact busy length
    bus_write(12'h120, 32'h0);
    for (int k = 0; k < 3; k++) begin
      int n;
      n = (k == 0) ? 1 : ((k == 1) ? 3 : NS);
      bus_write(12'h104, 32'(n - 1) << 8);
      bus_write(12'h100, 32'h1);
      repeat (n * STEP - 1) @(negedge clk);
      bus_read(12'h10C, v); chk("R4 still busy on last cycle", v, 0);
      bus_read(12'h10C, v); chk("R4 idle right after run", v, 1);
      bus_read(12'h110, v); chk("R4 sectors completed", v, (32'h1 << n) - 1);
      bus_read(12'h124, v);
      bus_write(12'h100, 32'h0);
    end

    // R6 read colliding with a new completion (step mode, 2 sectors)
    bus_write(12'h120, 32'h1);
    bus_write(12'h104, 32'h0000_0100);
    bus_write(12'h100, 32'h1);
    repeat (2 * STEP) @(negedge clk);
    bus_read(12'h110, v); chk("R6 mask read at collision", v, 32'h1);
    bus_read(12'h110, v); chk("R6 mask bit kept on collision", v, 32'h2);
    bus_read(12'h124, v);
    bus_write(12'h100, 32'h0);
    bus_read(12'h124, v); chk("R6 status drained", v, 0);
    bus_write(12'h100, 32'h1);
    repeat (2 * STEP) @(negedge clk);
    bus_read(12'h124, v); chk("R6 status read at collision", v, 1);
    bus_read(12'h124, v); chk("R6 status kept on collision", v, 1);
    bus_read(12'h124, v); chk("R6 status cleared after", v, 0);
    bus_read(12'h110, v);
    bus_write(12'h100, 32'h0);

    // R3 stop mid-run
    bus_write(12'h120, 32'h0);
    bus_write(12'h104, 32'h0000_0300);
    bus_write(12'h100, 32'h1);
    repeat (STEP + 1) @(negedge clk);
    bus_write(12'h100, 32'h0);
    bus_read(12'h10C, v); chk("R3 idle after stop", v, 1);
    repeat (5 * STEP) @(negedge clk);
    bus_read(12'h110, v); chk("R3 no sectors after stop", v, 32'h1);
    bus_read(12'h124, v);

    // R9 config lock and sticky error
    bus_write(12'h104, 32'h0000_0700);
    bus_write(12'h100, 32'h1);
    bus_write(12'h104, 32'h0000_DEAD);
    bus_read(12'h104, v); chk("R9 dec cfg unchanged", v, 32'h0000_0700);
    bus_read(12'h140, v); chk("R9 dec error flag", v, 2);
    bus_write(12'h004, 32'h0000_0200);
    bus_read(12'h004, v); chk("R9 enc cfg write while idle", v, 32'h0000_0200);
    bus_read(12'h140, v); chk("R9 error unaffected", v, 2);
    bus_write(12'h000, 32'h1);
    bus_write(12'h004, 32'h0000_BEEF);
    bus_read(12'h140, v); chk("R9 both error flags", v, 3);
    bus_write(12'h140, 32'h2);
    bus_read(12'h140, v); chk("R9 error clear dec only", v, 1);
    bus_write(12'h140, 32'h1);
    bus_read(12'h140, v); chk("R9 error clear enc", v, 0);
    bus_write(12'h000, 32'h0);
    bus_write(12'h100, 32'h0);

    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule